// File: doc/BRIEF.md
# Dual-Channel Output Compare Unit

This block watches a free-running counter that arrives on an input bus and compares it against two software-programmed compare values, one per channel. When the counter moves onto a channel's compare value, the channel raises a sticky match flag. The flag can request an interrupt, and it can drive a chosen fixed level onto the channel's output pin. Software reaches the compare values, a control word and the flag word through a small register port. Every access completes in the cycle it is presented, so the port has no back-pressure.

The compare values come out of reset as all ones. They are forced back to all ones for as long as the low-power input is held. Each output pin starts at 0 and stays there until its first enabled match.

Top module: `ocu_top`

## Requirements
- R1: After reset both compare registers read 0xFFFF, the control word and the flag word read 0, and both output pins and both interrupt lines are 0.
- R2: Register addresses are: 0 = channel A compare, 1 = channel B compare, 2 = control, 3 = flags. A write to address 0, 1 or 2 is read back unchanged, with the control word holding only bits [5:0]. Reads are combinational on `bus_rdata`.
- R3: When `cnt_i` changes to a value equal to a channel's compare register, that channel's flag reads 1 after the next clock edge. The flag word at address 3 holds A in bit 0 and B in bit 1.
- R4: No match occurs while `cnt_i` holds its value. This includes writing a compare register to the current count.
- R5: Control bits [1:0] are the interrupt enables for A and B. `irq[i]` equals channel i's flag AND its enable, registered one cycle later, so it is low whenever the enable is 0.
- R6: Control bits [3:2] are the output enables and bits [5:4] are the levels, A then B. On a match with its output enable at 1, the pin takes the level bit at the same edge that sets the flag. The pin is 0 from reset until such a match.
- R7: With a channel's output enable at 0, its pin keeps its last level through matches.
- R8: A flag clears only when the flag word is read while that flag is 1 and a later flag write carries 0 in that bit, with no flag write in between. Writing 1 has no effect, and writing 0 without the prior read leaves the flag set.
- R9: A match in the same cycle as a valid clear leaves the flag at 1.
- R10: While `lowpwr` is 1, both compare registers are forced to 0xFFFF, compare writes are dropped, and no match is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lowpwr | input | 1 | Low-power reinitialisation request |
| cnt_i | input | 16 | Free-running counter value |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| cmp_pin | output | 2 | Compare output pins, bit 0 = A |
| irq | output | 2 | Interrupt requests, bit 0 = A |

## Verification
A corrupted compare register or a lost change-detect history appears at the ports one edge after the counter steps: the pin level or the flag read is wrong, and the interrupt line is wrong one cycle after that. A bad clear-arming bit stays hidden until the next flag write. The flag word then reads back wrong on the following read. Low-power faults show up on the first compare read after `lowpwr` falls.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
  localparam int unsigned CTL_FIELDS = 3;

  typedef struct packed {
    logic lvl;
    logic oe;
    logic ie;
  } chan_ctl_t;
endpackage

// File: rtl/ocu_cntwatch.sv
module ocu_cntwatch #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_i,
  output logic          chg_o
);
  logic [CW-1:0] prev_q;
  logic          vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      prev_q <= cnt_i;
      vld_q  <= 1'b1;
    end
  end

  assign chg_o = vld_q && (cnt_i != prev_q);
endmodule

// File: rtl/ocu_chan.sv
module ocu_chan #(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lowpwr,
  input  logic              chg,
  input  logic [CW-1:0]     cnt_i,
  input  logic              cmp_we,
  input  logic [CW-1:0]     wdata,
  input  logic              sts_rd,
  input  logic              sts_wr,
  input  logic              clr_bit,
  input  ocu_pkg::chan_ctl_t ctl,
  output logic [CW-1:0]     cmp_q,
  output logic              flag_q,
  output logic              irq_q,
  output logic              pin_q
);
  logic arm_q;
  logic hit;

  assign hit = chg && !lowpwr && (cnt_i == cmp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q  <= '1;
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
      irq_q  <= 1'b0;
      pin_q  <= 1'b0;
    end else begin
      if (lowpwr)      cmp_q <= '1;
      else if (cmp_we) cmp_q <= wdata;

      if (hit)                               flag_q <= 1'b1;
      else if (sts_wr && !clr_bit && arm_q)  flag_q <= 1'b0;

      if (sts_wr)                arm_q <= 1'b0;
      else if (sts_rd && flag_q) arm_q <= 1'b1;

      irq_q <= flag_q & ctl.ie;

      if (hit && ctl.oe) pin_q <= ctl.lvl;
    end
  end
endmodule

// File: rtl/ocu_regs.sv
module ocu_regs #(
  parameter int CW  = 16,
  parameter int NCH = 2,
  parameter int AW  = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           lowpwr,
  input  logic                           bus_rd,
  input  logic                           bus_wr,
  input  logic [AW-1:0]                  bus_addr,
  input  logic [CW-1:0]                  bus_wdata,
  input  logic [NCH-1:0][CW-1:0]         cmp_q,
  input  logic [NCH-1:0]                 flag_q,
  output logic [NCH-1:0]                 cmp_we,
  output logic                           sts_rd,
  output logic                           sts_wr,
  output ocu_pkg::chan_ctl_t [NCH-1:0]   ctl_o,
  output logic [CW-1:0]                  bus_rdata
);
  localparam int        CTLW     = ocu_pkg::CTL_FIELDS * NCH;
  localparam logic [AW-1:0] A_CTL = AW'(NCH);
  localparam logic [AW-1:0] A_STS = AW'(NCH + 1);

  logic [CTLW-1:0] ctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                            ctl_q <= '0;
    else if (bus_wr && bus_addr == A_CTL)  ctl_q <= bus_wdata[CTLW-1:0];
  end

  assign sts_rd = bus_rd && (bus_addr == A_STS);
  assign sts_wr = bus_wr && (bus_addr == A_STS);

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    assign cmp_we[i]    = bus_wr && !lowpwr && (bus_addr == AW'(i));
    assign ctl_o[i].ie  = ctl_q[i];
    assign ctl_o[i].oe  = ctl_q[NCH + i];
    assign ctl_o[i].lvl = ctl_q[2*NCH + i];
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NCH; i++)
      if (bus_addr == AW'(i)) bus_rdata = cmp_q[i];
    if (bus_addr == A_CTL) bus_rdata[CTLW-1:0] = ctl_q;
    if (bus_addr == A_STS) bus_rdata[NCH-1:0]  = flag_q;
  end
endmodule

// File: rtl/ocu_top.sv
module ocu_top #(
  parameter int CW  = 16,
  parameter int NCH = 2,
  parameter int AW  = $clog2(NCH + 2)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           lowpwr,
  input  logic [CW-1:0]  cnt_i,
  input  logic           bus_rd,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [CW-1:0]  bus_wdata,
  output logic [CW-1:0]  bus_rdata,
  output logic [NCH-1:0] cmp_pin,
  output logic [NCH-1:0] irq
);
  logic                         chg_w;
  logic [NCH-1:0][CW-1:0]       cmp_w;
  logic [NCH-1:0]               flag_w;
  logic [NCH-1:0]               cmp_we_w;
  logic                         sts_rd_w;
  logic                         sts_wr_w;
  ocu_pkg::chan_ctl_t [NCH-1:0] ctl_w;

  ocu_cntwatch #(.CW(CW)) watch_i (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt_i (cnt_i),
    .chg_o (chg_w)
  );

  ocu_regs #(.CW(CW), .NCH(NCH), .AW(AW)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lowpwr    (lowpwr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cmp_q     (cmp_w),
    .flag_q    (flag_w),
    .cmp_we    (cmp_we_w),
    .sts_rd    (sts_rd_w),
    .sts_wr    (sts_wr_w),
    .ctl_o     (ctl_w),
    .bus_rdata (bus_rdata)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    ocu_chan #(.CW(CW)) chan_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .lowpwr  (lowpwr),
      .chg     (chg_w),
      .cnt_i   (cnt_i),
      .cmp_we  (cmp_we_w[i]),
      .wdata   (bus_wdata),
      .sts_rd  (sts_rd_w),
      .sts_wr  (sts_wr_w),
      .clr_bit (bus_wdata[i]),
      .ctl     (ctl_w[i]),
      .cmp_q   (cmp_w[i]),
      .flag_q  (flag_w[i]),
      .irq_q   (irq[i]),
      .pin_q   (cmp_pin[i])
    );
  end
endmodule

// File: rtl/ocu_chk.sv
module ocu_chk #(
  parameter int CW  = 16,
  parameter int NCH = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         lowpwr,
  input logic [CW-1:0]                cnt_i,
  input logic [NCH-1:0][CW-1:0]       cmp,
  input logic [NCH-1:0]               flag,
  input ocu_pkg::chan_ctl_t [NCH-1:0] ctl,
  input logic [NCH-1:0]               pin,
  input logic [NCH-1:0]               irq
);
  logic [1:0] seen;

  always_ff @(posedge clk) begin
    if (!rst_n)          seen <= 2'd0;
    else if (seen != 2'd2) seen <= seen + 2'd1;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_a
    // R10
    lowpwr_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lowpwr |=> (cmp[i] == '1));
    // R10
    lowpwr_nomatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen != 2'd0) && $past(lowpwr) |-> !$rose(flag[i]));
    // R5
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen != 2'd0) |-> (irq[i] == $past(flag[i] & ctl[i].ie)));
    // R6
    pin_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen != 2'd0) && $rose(flag[i]) && $past(ctl[i].oe) |-> (pin[i] == $past(ctl[i].lvl)));
    // R7
    pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen != 2'd0) && !$past(ctl[i].oe) |-> $stable(pin[i]));
    // R4
    no_static_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen == 2'd2) && $rose(flag[i]) |-> ($past(cnt_i) != $past(cnt_i, 2)) && ($past(cnt_i) == $past(cmp[i])));
  end
endmodule

bind ocu_top ocu_chk #(.CW(CW), .NCH(NCH)) chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .lowpwr (lowpwr),
  .cnt_i  (cnt_i),
  .cmp    (cmp_w),
  .flag   (flag_w),
  .ctl    (ctl_w),
  .pin    (cmp_pin),
  .irq    (irq)
);

// File: tb/ocu_top_tb_top.sv
module ocu_top_tb_top;
  localparam int CLK_PER = 10;
  localparam int CW = 16;
  localparam int NCH = 2;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lowpwr = 1'b0;
  logic [CW-1:0] cnt = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [CW-1:0] bus_wdata = '0;
  logic [CW-1:0] bus_rdata;
  logic [NCH-1:0] cmp_pin, irq;

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [CW-1:0] last_rd, last_exp;

  ocu_top dut_i (
    .clk(clk), .rst_n(rst_n), .lowpwr(lowpwr), .cnt_i(cnt),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmp_pin(cmp_pin), .irq(irq)
  );

  always #(CLK_PER/2) clk = ~clk;

  // reference model built from the requirements
  logic [CW-1:0]  m_cmp [NCH];
  logic [CW-1:0]  m_prev;
  logic           m_pvld;
  logic [5:0]     m_ctl;
  logic [NCH-1:0] m_flag, m_arm, m_pin, m_irq, m_hit;
  logic           m_chg;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) m_cmp[i] <= '1;
      m_prev <= '0; m_pvld <= 1'b0; m_ctl <= '0;
      m_flag <= '0; m_arm <= '0; m_pin <= '0; m_irq <= '0;
    end else begin
      m_chg = m_pvld && (cnt != m_prev);
      for (int i = 0; i < NCH; i++) begin
        m_hit[i] = m_chg && !lowpwr && (cnt == m_cmp[i]);
        m_irq[i] <= m_flag[i] & m_ctl[i];
        if (m_hit[i]) m_flag[i] <= 1'b1;
        else if (bus_wr && bus_addr == 2'd3 && !bus_wdata[i] && m_arm[i]) m_flag[i] <= 1'b0;
        if (bus_wr && bus_addr == 2'd3) m_arm[i] <= 1'b0;
        else if (bus_rd && bus_addr == 2'd3 && m_flag[i]) m_arm[i] <= 1'b1;
        if (m_hit[i] && m_ctl[NCH+i]) m_pin[i] <= m_ctl[2*NCH+i];
        if (lowpwr) m_cmp[i] <= '1;
        else if (bus_wr && bus_addr == AW'(i)) m_cmp[i] <= bus_wdata;
      end
      if (bus_wr && bus_addr == 2'd2) m_ctl <= bus_wdata[5:0];
      m_prev <= cnt; m_pvld <= 1'b1;
    end
  end

  function automatic logic [CW-1:0] exp_rd(input logic [AW-1:0] a);
    case (a)
      2'd0: return m_cmp[0];
      2'd1: return m_cmp[1];
      2'd2: return {10'd0, m_ctl};
      default: return {14'd0, m_flag};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // one clock cycle: drive after a falling edge, return at the next falling edge
  task automatic cyc(input logic rd, input logic wr, input logic [AW-1:0] a,
                     input logic [CW-1:0] d, input logic [CW-1:0] c, input logic lp);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d; cnt = c; lowpwr = lp;
    #1;
    last_rd  = bus_rdata;
    last_exp = exp_rd(a);
    @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a); cyc(1, 0, a, '0, cnt, 0); endtask
  task automatic wr(input logic [AW-1:0] a, input logic [CW-1:0] d); cyc(0, 1, a, d, cnt, 0); endtask
  task automatic step(input logic [CW-1:0] c); cyc(0, 0, 2'd0, '0, c, 0); endtask

  initial begin
    #(CLK_PER * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pins after reset", cmp_pin, 0);
    chk("R1 irq after reset", irq, 0);
    rd(0); chk("R1 cmp A reset", last_rd, 16'hFFFF);
    rd(1); chk("R1 cmp B reset", last_rd, 16'hFFFF);
    rd(2); chk("R1 ctl reset", last_rd, 0);
    rd(3); chk("R1 flags reset", last_rd, 0);

    wr(0, 16'h0010); wr(1, 16'h0020); wr(2, 16'h0037);
    rd(0); chk("R2 cmp A readback", last_rd, 16'h0010);
    rd(1); chk("R2 cmp B readback", last_rd, 16'h0020);
    rd(2); chk("R2 ctl readback", last_rd, 16'h0037);

    step(16'h0010);
    chk("R6 pin A driven on match", cmp_pin, 2'b01);
    chk("R5 irq not yet", irq, 2'b00);
    step(16'h0010);
    chk("R5 irq one cycle after flag", irq, 2'b01);
    rd(3); chk("R3 flag A set", last_rd, 16'h0001);

    wr(1, 16'h0010); step(16'h0010); step(16'h0010);
    rd(3); chk("R4 no match on write equal to count", last_rd, 16'h0001);

    step(16'h0011); step(16'h0010);
    chk("R7 pin B holds with oe off", cmp_pin, 2'b01);
    rd(3); chk("R3 both flags set", last_rd, 16'h0003);

    wr(3, 16'hFFFF); wr(3, 16'h0000);
    rd(3); chk("R8 no clear without prior read", last_rd, 16'h0003);
    wr(3, 16'h0002);
    rd(3); chk("R8 read then write 0 clears A only", last_rd, 16'h0002);
    chk("R5 irq follows cleared flag", irq, 2'b10);

    step(16'h0011);
    cyc(0, 1, 2'd3, 16'h0000, 16'h0010, 0);
    rd(3); chk("R9 match beats clear", last_rd, 16'h0003);
    wr(3, 16'h0000);
    rd(3); chk("R8 clear both after read", last_rd, 16'h0000);

    wr(2, 16'h002F); step(16'h0011); step(16'h0010);
    chk("R6 pins take programmed levels", cmp_pin, 2'b10);
    wr(2, 16'h0013); step(16'h0011); step(16'h0010);
    chk("R7 pins hold with oe off", cmp_pin, 2'b10);
    wr(2, 16'h0000); step(16'h0010);
    chk("R5 irq low with enables off", irq, 2'b00);

    rd(3); wr(3, 16'h0000);
    cyc(0, 1, 2'd0, 16'h1234, 16'hFFFF, 1);
    cyc(0, 0, 2'd0, 16'h0000, 16'hFFFF, 1);
    cyc(0, 0, 2'd0, 16'h0000, 16'hFFFF, 0);
    rd(0); chk("R10 cmp A forced, write dropped", last_rd, 16'hFFFF);
    rd(1); chk("R10 cmp B forced", last_rd, 16'hFFFF);
    rd(3); chk("R10 no match during low power", last_rd, 16'h0000);

    for (int n = 0; n < 2500; n++) begin
      logic [CW-1:0] c;
      logic lp;
      int op;
      c  = ($urandom % 2) ? cnt : CW'($urandom % 8);
      lp = ($urandom % 50) == 0;
      op = $urandom % 8;
      case (op)
        3: cyc(1, 0, 2'd3, '0, c, lp);
        4: cyc(0, 1, 2'd3, CW'($urandom % 4), c, lp);
        5: cyc(0, 1, AW'($urandom % 2), CW'($urandom % 8), c, lp);
        6: cyc(0, 1, 2'd2, CW'($urandom % 64), c, lp);
        7: cyc(1, 0, AW'($urandom % 4), '0, c, lp);
        default: cyc(0, 0, 2'd0, '0, c, lp);
      endcase
      chk("R6 random pins", cmp_pin, m_pin);
      chk("R5 random irq", irq, m_irq);
      chk("R3 random readback", last_rd, last_exp);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule